// File: doc/BRIEF.md
# Microcontroller Power Mode Sequencer

This block moves a small microcontroller between four power modes: active, idle, standby and shutdown. Software picks a target mode and then pulses a one-cycle sleep trigger. The sequencer then runs a short entry phase and settles in the new mode. In each mode it drives clock enables for the CPU, the peripherals and the high-speed clock. It also drives power enables for the CPU/memory domain and the always-on domain.

Each low-power mode has its own exit path. Idle resumes on any interrupt. Standby resumes without a reset on an RTC event or on a change at an enabled wake pin. Shutdown wakes only on a change at an enabled wake pin, and that wake is handled as a full reset. Every exit waits out a wake latency, set as a parameter in clock cycles. During that wait the domains come up in a fixed order.

Pad outputs are frozen while the device is in standby or shutdown. A reset-cause register records whether the last restart came from power-on, from the external reset pin, or from a shutdown pin wake. A held reset pin overrides every mode.

Top module: `pwr_mode_seq`

## Requirements
- R1: After power-on (`por_n` rising), the block performs a cold start. `cpu_rst` stays high and `cpu_clk_en` stays low for exactly T_SHUT clock edges. Then `cpu_clk_en` rises and `reset_cause` reads 1.
- R2: `mode_req` encodes 0 = active, 1 = idle, 2 = standby, 3 = shutdown. A mode change starts only on a `sleep_go` pulse while active, and `sleep_go` with `mode_req` = 0 is ignored. During the ENTRY_CYC-cycle entry phase, `cpu_clk_en` is low.
- R3: In idle, `cpu_clk_en` is low while `periph_clk_en`, `hf_clk_en`, `core_pwr_en` and `aon_pwr_en` stay high.
- R4: In idle, any set bit of `irq` starts the wake. `cpu_clk_en` rises T_IDLE edges after the edge that sampled the interrupt, and `cpu_rst` stays low.
- R5: In standby, only `aon_pwr_en` is high among the enables, and `retain` is high. Interrupts do not wake it.
- R6: Standby wakes on `rtc_evt`, which is sampled directly, or on a change at an enabled wake pin, which passes through SYNC_STAGES flops. The wake takes T_STBY cycles, `cpu_rst` stays low throughout, and `retain` stays high until active.
- R7: In shutdown, every enable is low, including `aon_pwr_en`, and `cpu_rst` is high. Neither `rtc_evt` nor `irq` wakes it.
- R8: In shutdown, a level change at an enabled wake pin, compared with the level sampled on entry, starts a reset wake. The wake lasts T_SHUT cycles after synchronization, `cpu_rst` stays high until active, and `reset_cause` becomes 3.
- R9: On entry to standby or shutdown, `io_pad` captures `io_out_in` and holds it, with `io_latch` high, until active resumes. After that, `io_pad` follows `io_out_in` again.
- R10: A low `rst_pin_n`, after synchronization, overrides any mode. All enables go low, `cpu_rst` goes high and `reset_cause` becomes 2. On release, a cold start of T_SHUT cycles follows.
- R11: During a wake from standby, shutdown or reset, `aon_pwr_en` and `core_pwr_en` are high from the start. `hf_clk_en` and `periph_clk_en` are high only for the last HF_LEAD cycles. `cpu_clk_en` rises only when the counter expires.
- R12: An `irq` bit or `rtc_evt` seen during the entry phase aborts the entry, and the block returns to active on the next edge.
- R13: Wake pins whose `wake_mask` bit was clear at entry are ignored in standby and shutdown.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sequencer clock |
| por_n | input | 1 | Power-on indication, active low, asynchronous |
| rst_pin_n | input | 1 | External reset pin, active low |
| mode_req | input | 2 | Target mode written by software |
| sleep_go | input | 1 | One-cycle trigger that starts the mode change |
| irq | input | N_IRQ | Interrupt lines |
| rtc_evt | input | 1 | RTC wake event |
| wake_pin | input | N_WPIN | Wake-capable pins (asynchronous) |
| wake_mask | input | N_WPIN | Wake enable per pin, sampled on entry |
| io_out_in | input | N_IO | Pad output values from the core |
| io_pad | output | N_IO | Pad output values after the freeze latch |
| cpu_clk_en | output | 1 | CPU/memory clock enable |
| periph_clk_en | output | 1 | Peripheral clock enable |
| hf_clk_en | output | 1 | High-speed clock enable |
| core_pwr_en | output | 1 | CPU/memory domain power enable |
| aon_pwr_en | output | 1 | Always-on domain power enable |
| retain | output | 1 | Register/memory retention flag |
| io_latch | output | 1 | Pad freeze active |
| cpu_rst | output | 1 | Reset to the CPU |
| reset_cause | output | 2 | Last reset cause: 1 power-on, 2 reset pin, 3 shutdown pin wake |

## Verification
The bench measures the cycle count of each wake path separately: idle, standby by RTC, standby by pin, shutdown by pin, reset pin release and power-on. A design that shared one latency, or that lost or added a synchronizer stage, would miss the exact count. It counts the high-speed clock cycles before active, which exposes an enable raised out of order. It checks that standby ignores interrupts, that shutdown ignores RTC events and interrupts, and that masked pins never wake either mode; a design with loose wake decoding would come up early. It also tests an interrupt during entry, the pad freeze across a changing core value, and whether each exit drives `cpu_rst`. A wrong exit type would show up as a spurious reset from standby or a missing one from shutdown.

// File: rtl/pms_pkg.sv
package pms_pkg;

   typedef enum logic [1:0] {
      PM_ACTIVE = 2'd0,
      PM_IDLE   = 2'd1,
      PM_STBY   = 2'd2,
      PM_SHUT   = 2'd3
   } pm_mode_e;

   typedef enum logic [2:0] {
      ST_ACTIVE,
      ST_ENTER,
      ST_IDLE,
      ST_STBY,
      ST_SHUT,
      ST_WAKE,
      ST_RHOLD
   } pm_state_e;

   typedef enum logic [1:0] {
      WS_IDLE,
      WS_STBY,
      WS_SHUT,
      WS_COLD
   } wake_src_e;

   localparam logic [1:0] RC_POR      = 2'd1;
   localparam logic [1:0] RC_PIN      = 2'd2;
   localparam logic [1:0] RC_SHUTWAKE = 2'd3;

endpackage

// File: rtl/pms_sync.sv
module pms_sync #(
   parameter int   W       = 1,
   parameter int   STAGES  = 2,
   parameter logic RST_VAL = 1'b0
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);

   logic [STAGES-1:0][W-1:0] stg;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) stg <= {(STAGES*W){RST_VAL}};
      else        stg <= {stg[STAGES-2:0], d};
   end

   assign q = stg[STAGES-1];

   initial begin
      assert (STAGES >= 2) else $error("pms_sync: STAGES must be at least 2");
      assert (W >= 1)      else $error("pms_sync: W must be at least 1");
   end

endmodule

// File: rtl/pms_wake_timer.sv
module pms_wake_timer
   import pms_pkg::*;
#(
   parameter int T_IDLE  = 700,
   parameter int T_STBY  = 7550,
   parameter int T_SHUT  = 50750,
   parameter int HF_LEAD = 8,
   parameter int CW      = $clog2(T_SHUT + 1)
) (
   input  logic      clk,
   input  logic      rst_n,
   input  logic      load,
   input  wake_src_e sel,
   output logic      expired,
   output logic      hf_win
);

   logic [CW-1:0] cnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt <= CW'(T_SHUT - 1);
      end else if (load) begin
         case (sel)
            WS_IDLE: cnt <= CW'(T_IDLE - 1);
            WS_STBY: cnt <= CW'(T_STBY - 1);
            default: cnt <= CW'(T_SHUT - 1);
         endcase
      end else if (cnt != '0) begin
         cnt <= cnt - 1'b1;
      end
   end

   assign expired = (cnt == '0);
   assign hf_win  = (cnt < CW'(HF_LEAD));

   // R11
   cnt_down_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!load && cnt != '0) |=> (cnt == $past(cnt) - 1'b1));

endmodule

// File: rtl/pms_wake_detect.sv
module pms_wake_detect #(
   parameter int W = 4
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         capture,
   input  logic [W-1:0] pins,
   input  logic [W-1:0] mask,
   output logic         hit
);

   logic [W-1:0] ref_lvl;
   logic [W-1:0] ref_msk;
   logic [W-1:0] diff;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ref_lvl <= '0;
         ref_msk <= '0;
      end else if (capture) begin
         ref_lvl <= pins;
         ref_msk <= mask;
      end
   end

   for (genvar i = 0; i < W; i++) begin : g_pin
      assign diff[i] = ref_msk[i] & (pins[i] ^ ref_lvl[i]);
   end

   assign hit = |diff;

   // R13
   masked_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (ref_msk == '0) |-> !hit);

endmodule

// File: rtl/pms_io_hold.sv
module pms_io_hold #(
   parameter int W = 8
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         capture,
   input  logic         hold,
   input  logic [W-1:0] din,
   output logic [W-1:0] dout
);

   logic [W-1:0] held;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       held <= '0;
      else if (capture) held <= din;
   end

   assign dout = hold ? held : din;

endmodule

// File: rtl/pwr_mode_seq.sv
module pwr_mode_seq
   import pms_pkg::*;
#(
   parameter int N_IRQ       = 4,
   parameter int N_WPIN      = 4,
   parameter int N_IO        = 8,
   parameter int T_IDLE      = 700,
   parameter int T_STBY      = 7550,
   parameter int T_SHUT      = 50750,
   parameter int HF_LEAD     = 8,
   parameter int ENTRY_CYC   = 4,
   parameter int SYNC_STAGES = 2
) (
   input  logic              clk,
   input  logic              por_n,
   input  logic              rst_pin_n,
   input  logic [1:0]        mode_req,
   input  logic              sleep_go,
   input  logic [N_IRQ-1:0]  irq,
   input  logic              rtc_evt,
   input  logic [N_WPIN-1:0] wake_pin,
   input  logic [N_WPIN-1:0] wake_mask,
   input  logic [N_IO-1:0]   io_out_in,
   output logic [N_IO-1:0]   io_pad,
   output logic              cpu_clk_en,
   output logic              periph_clk_en,
   output logic              hf_clk_en,
   output logic              core_pwr_en,
   output logic              aon_pwr_en,
   output logic              retain,
   output logic              io_latch,
   output logic              cpu_rst,
   output logic [1:0]        reset_cause
);

   localparam int EW = $clog2(ENTRY_CYC + 1);

   pm_state_e         state, nxt;
   wake_src_e         src, load_sel;
   pm_mode_e          target;
   logic [EW-1:0]     ecnt;
   logic [1:0]        cause;
   logic              load, cap, tmr_done, hf_win, pin_hit, rst_held, any_irq;
   logic [N_WPIN-1:0] pin_s;
   logic              rst_s;

   pms_sync #(.W(N_WPIN), .STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_pin_sync (
      .clk(clk), .rst_n(por_n), .d(wake_pin), .q(pin_s));

   pms_sync #(.W(1), .STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_rst_sync (
      .clk(clk), .rst_n(por_n), .d(rst_pin_n), .q(rst_s));

   pms_wake_detect #(.W(N_WPIN)) u_wdet (
      .clk(clk), .rst_n(por_n), .capture(cap), .pins(pin_s),
      .mask(wake_mask), .hit(pin_hit));

   pms_wake_timer #(.T_IDLE(T_IDLE), .T_STBY(T_STBY), .T_SHUT(T_SHUT),
                    .HF_LEAD(HF_LEAD)) u_tmr (
      .clk(clk), .rst_n(por_n), .load(load), .sel(load_sel),
      .expired(tmr_done), .hf_win(hf_win));

   pms_io_hold #(.W(N_IO)) u_iohold (
      .clk(clk), .rst_n(por_n), .capture(cap), .hold(io_latch),
      .din(io_out_in), .dout(io_pad));

   assign rst_held = !rst_s;
   assign any_irq  = |irq;

   always_comb begin
      nxt      = state;
      load     = 1'b0;
      load_sel = src;
      cap      = 1'b0;
      if (rst_held) begin
         nxt = ST_RHOLD;
      end else begin
         case (state)
            ST_ACTIVE: if (sleep_go && mode_req != PM_ACTIVE) nxt = ST_ENTER;
            ST_ENTER: begin
               if (any_irq || rtc_evt) begin
                  nxt = ST_ACTIVE;
               end else if (ecnt == '0) begin
                  case (target)
                     PM_IDLE: nxt = ST_IDLE;
                     PM_STBY: begin nxt = ST_STBY; cap = 1'b1; end
                     default: begin nxt = ST_SHUT; cap = 1'b1; end
                  endcase
               end
            end
            ST_IDLE: if (any_irq) begin
               nxt = ST_WAKE; load = 1'b1; load_sel = WS_IDLE;
            end
            ST_STBY: if (rtc_evt || pin_hit) begin
               nxt = ST_WAKE; load = 1'b1; load_sel = WS_STBY;
            end
            ST_SHUT: if (pin_hit) begin
               nxt = ST_WAKE; load = 1'b1; load_sel = WS_SHUT;
            end
            ST_WAKE: if (tmr_done) nxt = ST_ACTIVE;
            default: begin
               nxt = ST_WAKE; load = 1'b1; load_sel = WS_COLD;
            end
         endcase
      end
   end

   always_ff @(posedge clk or negedge por_n) begin
      if (!por_n) begin
         state  <= ST_WAKE;
         src    <= WS_COLD;
         target <= PM_IDLE;
         ecnt   <= '0;
      end else begin
         state <= nxt;
         if (load) src <= load_sel;
         if (state == ST_ACTIVE && nxt == ST_ENTER) begin
            target <= pm_mode_e'(mode_req);
            ecnt   <= EW'(ENTRY_CYC - 1);
         end else if (state == ST_ENTER && ecnt != '0) begin
            ecnt <= ecnt - 1'b1;
         end
      end
   end

   always_ff @(posedge clk or negedge por_n) begin
      if (!por_n)                              cause <= RC_POR;
      else if (rst_held)                       cause <= RC_PIN;
      else if (state == ST_SHUT && pin_hit)    cause <= RC_SHUTWAKE;
   end

   assign reset_cause = cause;

   always_comb begin
      logic fast_up;
      fast_up       = (state == ST_WAKE) && (src == WS_IDLE || hf_win);
      cpu_clk_en    = (state == ST_ACTIVE);
      aon_pwr_en    = (state == ST_ACTIVE) || (state == ST_ENTER) || (state == ST_IDLE) ||
                      (state == ST_STBY)   || (state == ST_WAKE);
      core_pwr_en   = (state == ST_ACTIVE) || (state == ST_ENTER) || (state == ST_IDLE) ||
                      (state == ST_WAKE);
      hf_clk_en     = (state == ST_ACTIVE) || (state == ST_ENTER) || (state == ST_IDLE) ||
                      fast_up;
      periph_clk_en = hf_clk_en;
      retain        = (state == ST_STBY) || (state == ST_WAKE && src == WS_STBY);
      io_latch      = (state == ST_STBY) || (state == ST_SHUT) ||
                      (state == ST_WAKE && (src == WS_STBY || src == WS_SHUT));
      cpu_rst       = (state == ST_RHOLD) || (state == ST_SHUT) ||
                      (state == ST_WAKE && (src == WS_SHUT || src == WS_COLD));
   end

   initial begin
      assert (HF_LEAD >= 1 && HF_LEAD < T_IDLE) else $error("HF_LEAD out of range");
      assert (T_IDLE <= T_STBY && T_STBY <= T_SHUT) else $error("latency order");
      assert (ENTRY_CYC >= 1) else $error("ENTRY_CYC must be at least 1");
      assert (SYNC_STAGES >= 2) else $error("SYNC_STAGES must be at least 2");
      assert (N_IRQ >= 1 && N_WPIN >= 1 && N_IO >= 1) else $error("widths");
   end

   // R11
   cpu_last_chk: assert property (@(posedge clk) disable iff (!por_n)
      cpu_clk_en |-> (aon_pwr_en && core_pwr_en && hf_clk_en));

   // R11
   hf_after_aon_chk: assert property (@(posedge clk) disable iff (!por_n)
      hf_clk_en |-> aon_pwr_en);

   // R7
   aon_off_all_off_chk: assert property (@(posedge clk) disable iff (!por_n)
      !aon_pwr_en |-> (!cpu_clk_en && !hf_clk_en && !periph_clk_en && !core_pwr_en && cpu_rst));

   // R5
   stby_irq_ignored_chk: assert property (@(posedge clk) disable iff (!por_n)
      (state == ST_STBY && !rtc_evt && !pin_hit && !rst_held) |=> (retain && !cpu_clk_en));

   // R9
   pad_frozen_chk: assert property (@(posedge clk) disable iff (!por_n)
      (io_latch && $past(io_latch)) |-> $stable(io_pad));

   // R4
   no_early_active_chk: assert property (@(posedge clk) disable iff (!por_n)
      (state == ST_WAKE && !tmr_done && !rst_held) |=> !cpu_clk_en);

   // R10
   rst_pin_override_chk: assert property (@(posedge clk) disable iff (!por_n)
      rst_held |=> (cpu_rst && !aon_pwr_en && reset_cause == RC_PIN));

   // R8
   cause_stable_chk: assert property (@(posedge clk) disable iff (!por_n)
      (!rst_held && !(state == ST_SHUT && pin_hit)) |=> $stable(reset_cause));

endmodule

// File: tb/pwr_mode_seq_bench.sv
`timescale 1ns/1ps
module pwr_mode_seq_bench;

   localparam int N_IRQ = 4, N_WPIN = 4, N_IO = 8;
   localparam int T_IDLE = 6, T_STBY = 12, T_SHUT = 20;
   localparam int HF_LEAD = 3, ENTRY_CYC = 4, SYNC = 2;

   logic clk = 1'b0;
   logic por_n = 1'b0, rst_pin_n = 1'b1, sleep_go = 1'b0, rtc_evt = 1'b0;
   logic [1:0] mode_req = 2'd0;
   logic [N_IRQ-1:0] irq = '0;
   logic [N_WPIN-1:0] wake_pin = '0, wake_mask = '0;
   logic [N_IO-1:0] io_out_in = '0, io_pad;
   logic cpu_clk_en, periph_clk_en, hf_clk_en, core_pwr_en, aon_pwr_en;
   logic retain, io_latch, cpu_rst;
   logic [1:0] reset_cause;

   int n_chk = 0;
   int n_fail = 0;

   always #10 clk = ~clk;

   pwr_mode_seq #(.N_IRQ(N_IRQ), .N_WPIN(N_WPIN), .N_IO(N_IO), .T_IDLE(T_IDLE),
      .T_STBY(T_STBY), .T_SHUT(T_SHUT), .HF_LEAD(HF_LEAD), .ENTRY_CYC(ENTRY_CYC),
      .SYNC_STAGES(SYNC)) u_pwr_mode_seq (
      .clk(clk), .por_n(por_n), .rst_pin_n(rst_pin_n), .mode_req(mode_req),
      .sleep_go(sleep_go), .irq(irq), .rtc_evt(rtc_evt), .wake_pin(wake_pin),
      .wake_mask(wake_mask), .io_out_in(io_out_in), .io_pad(io_pad),
      .cpu_clk_en(cpu_clk_en), .periph_clk_en(periph_clk_en), .hf_clk_en(hf_clk_en),
      .core_pwr_en(core_pwr_en), .aon_pwr_en(aon_pwr_en), .retain(retain),
      .io_latch(io_latch), .cpu_rst(cpu_rst), .reset_cause(reset_cause));

   task automatic chk(input string req, input string what, input int act, input int exp);
      n_chk++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
      end
   endtask

   task automatic summary();
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   endtask

   task automatic wait_active(output int n, output int hfn, output int rsth, output int ret_lo);
      n = 0; hfn = 0; rsth = 0; ret_lo = 0;
      while (n < 2000) begin
         @(posedge clk);
         n++;
         @(negedge clk);
         if (cpu_clk_en) break;
         if (hf_clk_en) hfn++;
         if (cpu_rst) rsth++;
         if (!retain) ret_lo++;
      end
   endtask

   task automatic go_mode(input logic [1:0] m);
      @(negedge clk);
      mode_req = m; sleep_go = 1'b1;
      @(negedge clk);
      sleep_go = 1'b0;
      repeat (ENTRY_CYC + 2) @(negedge clk);
   endtask

   task automatic t_por();
      int n, hfn, rsth, rl;
      @(negedge clk);
      chk("R1", "cpu_clk_en in reset", cpu_clk_en, 0);
      chk("R1", "cpu_rst in reset", cpu_rst, 1);
      chk("R1", "aon_pwr_en in reset", aon_pwr_en, 1);
      por_n = 1'b1;
      wait_active(n, hfn, rsth, rl);
      chk("R1", "power-on latency", n, T_SHUT);
      chk("R1", "cpu_rst held during cold start", rsth, n - 1);
      chk("R1", "reset_cause after power-on", reset_cause, 1);
      chk("R11", "hf cycles before active (cold)", hfn, HF_LEAD);
   endtask

   task automatic t_active_req_ignored();
      @(negedge clk);
      mode_req = 2'd0; sleep_go = 1'b1;
      @(negedge clk);
      sleep_go = 1'b0;
      repeat (ENTRY_CYC + 3) @(negedge clk);
      chk("R2", "cpu_clk_en after request of active", cpu_clk_en, 1);
   endtask

   task automatic t_idle();
      int n, hfn, rsth, rl;
      go_mode(2'd1);
      chk("R3", "idle cpu_clk_en", cpu_clk_en, 0);
      chk("R3", "idle periph_clk_en", periph_clk_en, 1);
      chk("R3", "idle hf/core/aon", {hf_clk_en, core_pwr_en, aon_pwr_en}, 3'b111);
      irq = 4'b0100;
      wait_active(n, hfn, rsth, rl);
      irq = '0;
      chk("R4", "idle wake latency", n, T_IDLE + 1);
      chk("R4", "cpu_rst during idle wake", rsth, 0);
   endtask

   task automatic t_abort();
      @(negedge clk);
      mode_req = 2'd2; sleep_go = 1'b1;
      @(negedge clk);
      sleep_go = 1'b0;
      chk("R2", "cpu_clk_en during entry", cpu_clk_en, 0);
      irq = 4'b0001;
      @(negedge clk);
      irq = '0;
      chk("R12", "active after abort", cpu_clk_en, 1);
      repeat (ENTRY_CYC + 4) @(negedge clk);
      chk("R12", "still active later", cpu_clk_en, 1);
      chk("R12", "no standby retain", retain, 0);
   endtask

   task automatic t_stby_rtc();
      int n, hfn, rsth, rl;
      io_out_in = 8'hA5;
      wake_mask = '0;
      go_mode(2'd2);
      chk("R5", "standby enables {aon,core,hf,periph,cpu}",
          {aon_pwr_en, core_pwr_en, hf_clk_en, periph_clk_en, cpu_clk_en}, 5'b10000);
      chk("R5", "standby retain", retain, 1);
      io_out_in = 8'h3C;
      @(negedge clk);
      chk("R9", "pad frozen in standby", io_pad, 8'hA5);
      chk("R9", "io_latch in standby", io_latch, 1);
      irq = 4'b1111;
      repeat (T_IDLE + 4) @(negedge clk);
      irq = '0;
      chk("R5", "irq ignored in standby", {cpu_clk_en, aon_pwr_en, hf_clk_en}, 3'b010);
      rtc_evt = 1'b1;
      wait_active(n, hfn, rsth, rl);
      rtc_evt = 1'b0;
      chk("R6", "standby rtc wake latency", n, T_STBY + 1);
      chk("R6", "no reset on standby wake", rsth, 0);
      chk("R6", "retain held during wake", rl, 0);
      chk("R11", "hf cycles before active (standby)", hfn, HF_LEAD);
      chk("R9", "pad follows core after wake", io_pad, 8'h3C);
   endtask

   task automatic t_stby_pin();
      int n, hfn, rsth, rl;
      wake_mask = 4'b0101;
      go_mode(2'd2);
      wake_pin[1] = ~wake_pin[1];
      repeat (SYNC + 8) @(negedge clk);
      chk("R13", "masked pin ignored in standby", {cpu_clk_en, retain}, 2'b01);
      wake_pin[2] = ~wake_pin[2];
      wait_active(n, hfn, rsth, rl);
      chk("R6", "standby pin wake latency", n, T_STBY + SYNC + 1);
      chk("R6", "no reset on pin wake from standby", rsth, 0);
   endtask

   task automatic t_shut();
      int n, hfn, rsth, rl;
      wake_mask = 4'b1000;
      io_out_in = 8'h81;
      go_mode(2'd3);
      chk("R7", "shutdown enables {aon,core,hf,periph,cpu}",
          {aon_pwr_en, core_pwr_en, hf_clk_en, periph_clk_en, cpu_clk_en}, 5'b00000);
      chk("R7", "cpu_rst in shutdown", cpu_rst, 1);
      io_out_in = 8'h18;
      @(negedge clk);
      chk("R9", "pad frozen in shutdown", io_pad, 8'h81);
      rtc_evt = 1'b1; irq = 4'b1010;
      wake_pin[0] = ~wake_pin[0];
      repeat (T_STBY + 4) @(negedge clk);
      rtc_evt = 1'b0; irq = '0;
      chk("R7", "rtc/irq ignored in shutdown", aon_pwr_en, 0);
      chk("R13", "masked pin ignored in shutdown", cpu_rst, 1);
      wake_pin[3] = ~wake_pin[3];
      wait_active(n, hfn, rsth, rl);
      chk("R8", "shutdown wake latency", n, T_SHUT + SYNC + 1);
      chk("R8", "cpu_rst through shutdown wake", rsth, n - 1);
      chk("R8", "reset_cause after pin wake", reset_cause, 3);
      chk("R11", "hf cycles before active (shutdown)", hfn, HF_LEAD);
      chk("R9", "pad released after shutdown wake", io_pad, 8'h18);
   endtask

   task automatic t_rstpin();
      int n, hfn, rsth, rl;
      go_mode(2'd1);
      rst_pin_n = 1'b0;
      repeat (SYNC + 3) @(negedge clk);
      chk("R10", "reset pin: aon off", aon_pwr_en, 0);
      chk("R10", "reset pin: cpu_rst", cpu_rst, 1);
      chk("R10", "reset pin: cause", reset_cause, 2);
      irq = 4'b0010;
      repeat (T_IDLE + 3) @(negedge clk);
      irq = '0;
      chk("R10", "held reset overrides irq", cpu_clk_en, 0);
      rst_pin_n = 1'b1;
      wait_active(n, hfn, rsth, rl);
      chk("R10", "reset release latency", n, T_SHUT + SYNC + 1);
      chk("R10", "cause kept after release", reset_cause, 2);
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      n_fail++;
      $display("FAIL R1 watchdog: actual timeout expected completion");
      summary();
   end

   initial begin
      repeat (3) @(negedge clk);
      t_por();
      t_active_req_ignored();
      t_idle();
      t_abort();
      t_stby_rtc();
      t_stby_pin();
      t_shut();
      t_rstpin();
      repeat (2) @(negedge clk);
      summary();
   end

endmodule